// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy peripheral combo chip. It sits on a byte-wide, ISA-style I/O bus and takes up two adjacent byte addresses. The even address is an index port that selects one of three internal configuration registers. The odd address is a data port that reads or writes the selected register. The three registers are function enable, function address, and power/test. Their values are driven out continuously, so that a separate resource decoder can place the on-chip peripherals. That decoder is not part of this block.

Software finds the chip by reading the index port. Straight after reset, that port returns a two-byte identification sequence before it shows the selected index. Any write to the index port cuts the sequence short. On reset, each register loads a default value. A 5-bit board strap picks the value from a 32-entry table for that register, so that a board can boot with its peripherals already placed. Bit 6 of the power/test register is a configuration lock. Once it is set, data-port writes have no effect until the next reset.

The bus is synchronous to `clk`. Each strobe that is high for one cycle with `chipSel` high counts as one access. Reset is synchronous and active high.

Top module: `sio_cfg_port`

## Requirements
- R1: An access takes place only in a cycle where `chipSel` and a strobe are both high. `addrLsb`=0 selects the index port and `addrLsb`=1 selects the data port.
- R2: Index 0 selects the function enable register (`enableReg`), index 1 selects the function address register (`addrReg`), and index 2 selects the power/test register (`powerReg`).
- R3: A data-port write loads `wrData` into the selected register when the index is 0, 1 or 2. When the index is 3 or higher, the write changes no register.
- R4: A data-port read returns the selected register when the index is 0, 1 or 2. When the index is 3 or higher, it returns 0x00.
- R5: After reset, the first index-port read returns 0x88 and the second returns 0x00. Every later index-port read returns the selected index.
- R6: An index-port write stores `wrData` as the selected index and ends the identification sequence. Every index-port read after it returns the stored index.
- R7: Reset sets the selected index to 0 and loads each register from its own 32-entry table, indexed by `strap`. Examples: strap 1 gives 0x4F/0x11/0x00, strap 6 gives 0x4B/0x00/0x00, strap 12 gives 0x0F/0x10/0x00, and strap 31 gives 0x00/0x10/0x02 (enable/address/power).
- R8: While bit 6 of `powerReg` is 1, data-port writes are ignored, and this lasts until the next reset. Index writes and reads keep working.
- R9: `rdData` is registered. It shows the result of a read in the cycle after the read strobe, keeps its value when no read takes place, and is 0x00 after reset.
- R10: When a read strobe and a write strobe are high in the same cycle, the read returns the state from before the write, and the write still takes effect.
- R11: Strobes with `chipSel` low change neither the registers nor `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addrLsb | input | 1 | Address bit 0: 0 = index port, 1 = data port |
| chipSel | input | 1 | Port pair selected by the bus address decode |
| rdStrobe | input | 1 | One-cycle read strobe |
| wrStrobe | input | 1 | One-cycle write strobe |
| wrData | input | 8 | Write data byte |
| strap | input | 5 | Board strap that selects the reset defaults |
| rdData | output | 8 | Registered read data |
| enableReg | output | 8 | Function enable register |
| addrReg | output | 8 | Function address register |
| powerReg | output | 8 | Power/test register (bit 6 = lock) |

## Verification
A read and a write can land in the same cycle. On the data port this means a register readback and a register update at once. On the index port it means the identification step advancing while the index is overwritten. The bench provokes this by raising both strobes together on one port. It then judges that `rdData` carries the old register content, or the old identification byte, while the register outputs, or the next index read, show the written value. The lock is also checked against a write in the cycle after the lock bit is set.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int DATA_W   = 8;
  localparam int STRAP_W  = 5;
  localparam int NUM_REGS = 3;
  localparam int REG_SEL_ENABLE = 0;
  localparam int REG_SEL_ADDR   = 1;
  localparam int REG_SEL_POWER  = 2;
  localparam int LOCK_BIT       = 6;
  localparam logic [DATA_W-1:0] ID_BYTE_FIRST  = 8'h88;
  localparam logic [DATA_W-1:0] ID_BYTE_SECOND = 8'h00;

  typedef enum logic [1:0] {
    ID_FIRST  = 2'd0,
    ID_SECOND = 2'd1,
    ID_DONE   = 2'd2
  } idPhase_t;

  // strobes from control to datapath, one access per cycle per port
  typedef struct packed {
    logic     idxWr;
    logic     dataWr;
    logic     idxRd;
    logic     dataRd;
    idPhase_t phase;
  } ctrlStrobes_t;

  function automatic logic [DATA_W-1:0] enableDefault(input logic [STRAP_W-1:0] s);
    logic [DATA_W-1:0] v;
    case (s) inside
      [5'd0:5'd5]:   v = 8'h4F;
      [5'd6:5'd11]:  v = 8'h4B;
      [5'd12:5'd15]: v = 8'h0F;
      [5'd16:5'd19]: v = 8'h49;
      [5'd20:5'd23]: v = 8'h07;
      [5'd24:5'd29]: v = 8'h47;
      5'd30:         v = 8'h08;
      default:       v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] addrDefault(input logic [STRAP_W-1:0] s);
    logic [DATA_W-1:0] v;
    case (s)
      5'd0:  v = 8'h10;  5'd1:  v = 8'h11;  5'd2:  v = 8'h11;  5'd3:  v = 8'h39;
      5'd4:  v = 8'h24;  5'd5:  v = 8'h38;  5'd6:  v = 8'h00;  5'd7:  v = 8'h01;
      5'd8:  v = 8'h01;  5'd9:  v = 8'h09;  5'd10: v = 8'h08;  5'd11: v = 8'h08;
      5'd12: v = 8'h10;  5'd13: v = 8'h11;  5'd14: v = 8'h39;  5'd15: v = 8'h24;
      5'd16: v = 8'h00;  5'd17: v = 8'h01;  5'd18: v = 8'h01;  5'd19: v = 8'h00;
      5'd20: v = 8'h10;  5'd21: v = 8'h11;  5'd22: v = 8'h39;  5'd23: v = 8'h24;
      5'd24: v = 8'h10;  5'd25: v = 8'h11;  5'd26: v = 8'h11;  5'd27: v = 8'h39;
      5'd28: v = 8'h24;  5'd29: v = 8'h38;  5'd30: v = 8'h10;  default: v = 8'h10;
    endcase
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] powerDefault(input logic [STRAP_W-1:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

  function automatic logic [DATA_W-1:0] strapDefault(input int regSel,
                                                     input logic [STRAP_W-1:0] s);
    case (regSel)
      REG_SEL_ENABLE: return enableDefault(s);
      REG_SEL_ADDR:   return addrDefault(s);
      REG_SEL_POWER:  return powerDefault(s);
      default:        return '0;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         addrLsb,
  input  logic         chipSel,
  input  logic         rdStrobe,
  input  logic         wrStrobe,
  output ctrlStrobes_t strobes
);

  idPhase_t phase;
  logic     idxWr, idxRd;

  assign idxWr = chipSel && wrStrobe && !addrLsb;
  assign idxRd = chipSel && rdStrobe && !addrLsb;

  // identification step: an index write ends it at once
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ID_FIRST;
    end else if (idxWr) begin
      phase <= ID_DONE;
    end else if (idxRd) begin
      case (phase)
        ID_FIRST:  phase <= ID_SECOND;
        ID_SECOND: phase <= ID_DONE;
        default:   phase <= ID_DONE;
      endcase
    end
  end

  always_comb begin
    strobes.idxWr  = idxWr;
    strobes.idxRd  = idxRd;
    strobes.dataWr = chipSel && wrStrobe && addrLsb;
    strobes.dataRd = chipSel && rdStrobe && addrLsb;
    strobes.phase  = phase;
  end

endmodule

// File: rtl/sio_cfg_datapath.sv
module sio_cfg_datapath
  import sio_cfg_pkg::*;
#(
  parameter int REG_COUNT = NUM_REGS,
  parameter int LOCK_POS  = LOCK_BIT,
  parameter int LOCK_REG  = REG_SEL_POWER
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrlStrobes_t                  strobes,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [STRAP_W-1:0]            strap,
  output logic [DATA_W-1:0]             rdData,
  output logic [REG_COUNT*DATA_W-1:0]   regsFlat
);

  localparam logic [DATA_W-1:0] LAST_IDX = DATA_W'(REG_COUNT);

  logic [DATA_W-1:0] selIndex;
  logic [DATA_W-1:0] regBank [REG_COUNT];
  logic              inRange, locked, writeOk;
  logic [DATA_W-1:0] readValue;
  logic [DATA_W-1:0] selValue;

  assign inRange = selIndex < LAST_IDX;
  assign locked  = regBank[LOCK_REG][LOCK_POS];
  assign writeOk = strobes.dataWr && inRange && !locked;

  always_ff @(posedge clk) begin
    if (rst)                selIndex <= '0;
    else if (strobes.idxWr) selIndex <= wrData;
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    localparam logic [DATA_W-1:0] MY_IDX = DATA_W'(g);
    always_ff @(posedge clk) begin
      if (rst)                                 regBank[g] <= strapDefault(g, strap);
      else if (writeOk && selIndex == MY_IDX)  regBank[g] <= wrData;
    end
    assign regsFlat[g*DATA_W +: DATA_W] = regBank[g];
  end

  always_comb begin
    selValue = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (selIndex == DATA_W'(i)) selValue = regBank[i];
    end
  end

  always_comb begin
    if (strobes.idxRd) begin
      case (strobes.phase)
        ID_FIRST:  readValue = ID_BYTE_FIRST;
        ID_SECOND: readValue = ID_BYTE_SECOND;
        default:   readValue = selIndex;
      endcase
    end else begin
      readValue = inRange ? selValue : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                    rdData <= '0;
    else if (strobes.idxRd || strobes.dataRd)   rdData <= readValue;
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               addrLsb,
  input  logic               chipSel,
  input  logic               rdStrobe,
  input  logic               wrStrobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [STRAP_W-1:0] strap,
  output logic [DATA_W-1:0]  rdData,
  output logic [DATA_W-1:0]  enableReg,
  output logic [DATA_W-1:0]  addrReg,
  output logic [DATA_W-1:0]  powerReg
);

  ctrlStrobes_t                 strobes;
  logic [NUM_REGS*DATA_W-1:0]   regsFlat;

  sio_cfg_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .addrLsb  (addrLsb),
    .chipSel  (chipSel),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .strobes  (strobes)
  );

  sio_cfg_datapath #(
    .REG_COUNT (NUM_REGS),
    .LOCK_POS  (LOCK_BIT),
    .LOCK_REG  (REG_SEL_POWER)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrData   (wrData),
    .strap    (strap),
    .rdData   (rdData),
    .regsFlat (regsFlat)
  );

  assign enableReg = regsFlat[REG_SEL_ENABLE*DATA_W +: DATA_W];
  assign addrReg   = regsFlat[REG_SEL_ADDR*DATA_W   +: DATA_W];
  assign powerReg  = regsFlat[REG_SEL_POWER*DATA_W  +: DATA_W];

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker (
  input logic       clk,
  input logic       rst,
  input logic       addrLsb,
  input logic       chipSel,
  input logic       rdStrobe,
  input logic       wrStrobe,
  input logic [7:0] rdData,
  input logic [7:0] enableReg,
  input logic [7:0] addrReg,
  input logic [7:0] powerReg
);

  logic       armed;
  logic [1:0] idxReads;
  logic       idxWritten;
  logic       idxRd, idxWr, dataWr;

  assign idxRd  = chipSel && rdStrobe && !addrLsb;
  assign idxWr  = chipSel && wrStrobe && !addrLsb;
  assign dataWr = chipSel && wrStrobe && addrLsb;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b1;
      idxReads   <= '0;
      idxWritten <= 1'b0;
    end else begin
      if (idxRd && idxReads != 2'd2) idxReads <= idxReads + 2'd1;
      if (idxWr) idxWritten <= 1'b1;
    end
  end

  assert_reset_clears_read_R9: assert property (@(posedge clk)
    rst |=> rdData == 8'h00);

  assert_idle_read_hold_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    !(chipSel && rdStrobe) |=> $stable(rdData));

  assert_first_id_byte_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (idxRd && idxReads == 2'd0 && !idxWritten) |=> rdData == 8'h88);

  assert_second_id_byte_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (idxRd && idxReads == 2'd1 && !idxWritten) |=> rdData == 8'h00);

  assert_regs_need_data_write_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    !dataWr |=> ($stable(enableReg) && $stable(addrReg) && $stable(powerReg)));

  assert_lock_freezes_regs_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    powerReg[6] |=> ($stable(enableReg) && $stable(addrReg) && $stable(powerReg)));

  assert_deselect_no_effect_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    !chipSel |=> ($stable(rdData) && $stable(enableReg) && $stable(addrReg) && $stable(powerReg)));

endmodule

bind sio_cfg_port sio_cfg_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .addrLsb   (addrLsb),
  .chipSel   (chipSel),
  .rdStrobe  (rdStrobe),
  .wrStrobe  (wrStrobe),
  .rdData    (rdData),
  .enableReg (enableReg),
  .addrReg   (addrReg),
  .powerReg  (powerReg)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addrLsb = 1'b0;
  logic       chipSel = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [4:0] strap = 5'd1;
  logic [7:0] rdData, enableReg, addrReg, powerReg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic IDX = 1'b0;
  localparam logic DAT = 1'b1;

  sio_cfg_port uut (
    .clk(clk), .rst(rst), .addrLsb(addrLsb), .chipSel(chipSel),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .wrData(wrData), .strap(strap),
    .rdData(rdData), .enableReg(enableReg), .addrReg(addrReg), .powerReg(powerReg)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic [4:0] s);
    @(negedge clk);
    strap = s;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic busWrite(input logic port, input logic [7:0] d);
    @(negedge clk);
    chipSel = 1'b1; addrLsb = port; wrStrobe = 1'b1; wrData = d;
    @(negedge clk);
    chipSel = 1'b0; wrStrobe = 1'b0;
  endtask

  task automatic busRead(input logic port, output logic [7:0] d);
    @(negedge clk);
    chipSel = 1'b1; addrLsb = port; rdStrobe = 1'b1;
    @(negedge clk);
    chipSel = 1'b0; rdStrobe = 1'b0;
    d = rdData;
  endtask

  task automatic testResetDefaults();
    logic [7:0] d;
    doReset(5'd1);
    check("R9", "rdData after reset", rdData, 8'h00);
    check("R7", "strap1 enable", enableReg, 8'h4F);
    check("R7", "strap1 address", addrReg, 8'h11);
    check("R7", "strap1 power", powerReg, 8'h00);
    busRead(DAT, d);
    check("R4", "data read at reset index 0", d, 8'h4F);
    doReset(5'd6);
    check("R7", "strap6 enable", enableReg, 8'h4B);
    check("R7", "strap6 address", addrReg, 8'h00);
    doReset(5'd12);
    check("R7", "strap12 enable", enableReg, 8'h0F);
    check("R7", "strap12 address", addrReg, 8'h10);
    doReset(5'd31);
    check("R7", "strap31 enable", enableReg, 8'h00);
    check("R7", "strap31 address", addrReg, 8'h10);
    check("R7", "strap31 power", powerReg, 8'h02);
  endtask

  task automatic testIdSequence();
    logic [7:0] d;
    doReset(5'd1);
    busRead(IDX, d); check("R5", "id first", d, 8'h88);
    busRead(IDX, d); check("R5", "id second", d, 8'h00);
    busWrite(IDX, 8'h02);
    busRead(IDX, d); check("R6", "index after write", d, 8'h02);
    doReset(5'd1);
    busRead(IDX, d); check("R5", "id first again", d, 8'h88);
    busWrite(IDX, 8'h01);
    busRead(IDX, d); check("R6", "id cut short", d, 8'h01);
    busRead(IDX, d); check("R6", "index repeat", d, 8'h01);
  endtask

  task automatic testRegAccess();
    logic [7:0] d;
    doReset(5'd1);
    busWrite(IDX, 8'h00); busWrite(DAT, 8'h5A);
    check("R2", "index0 is enable", enableReg, 8'h5A);
    busWrite(IDX, 8'h01); busWrite(DAT, 8'hA5);
    check("R2", "index1 is address", addrReg, 8'hA5);
    busWrite(IDX, 8'h02); busWrite(DAT, 8'h03);
    check("R2", "index2 is power", powerReg, 8'h03);
    busRead(DAT, d); check("R4", "read power", d, 8'h03);
    busWrite(IDX, 8'h01);
    busRead(DAT, d); check("R1", "data port read address", d, 8'hA5);
    check("R3", "enable untouched", enableReg, 8'h5A);
  endtask

  task automatic testOutOfRange();
    logic [7:0] d;
    doReset(5'd1);
    busWrite(IDX, 8'h03); busWrite(DAT, 8'h77);
    check("R3", "idx3 write enable", enableReg, 8'h4F);
    check("R3", "idx3 write address", addrReg, 8'h11);
    check("R3", "idx3 write power", powerReg, 8'h00);
    busRead(DAT, d); check("R4", "idx3 read", d, 8'h00);
    busWrite(IDX, 8'hFF); busWrite(DAT, 8'h40);
    check("R3", "idxFF write power", powerReg, 8'h00);
    busRead(DAT, d); check("R4", "idxFF read", d, 8'h00);
  endtask

  task automatic testLock();
    logic [7:0] d;
    doReset(5'd1);
    busWrite(IDX, 8'h02); busWrite(DAT, 8'h40);
    check("R8", "lock set", powerReg, 8'h40);
    busWrite(DAT, 8'h00);
    check("R8", "locked power write", powerReg, 8'h40);
    busWrite(IDX, 8'h00); busWrite(DAT, 8'h12);
    check("R8", "locked enable write", enableReg, 8'h4F);
    busRead(IDX, d); check("R8", "index works when locked", d, 8'h00);
    busRead(DAT, d); check("R8", "read works when locked", d, 8'h4F);
    doReset(5'd31);
    busWrite(DAT, 8'h33);
    check("R8", "unlocked after reset", enableReg, 8'h33);
  endtask

  task automatic testDeselect();
    logic [7:0] d;
    doReset(5'd1);
    busRead(DAT, d);
    @(negedge clk);
    addrLsb = DAT; wrStrobe = 1'b1; rdStrobe = 1'b1; wrData = 8'h99; chipSel = 1'b0;
    @(negedge clk);
    wrStrobe = 1'b0; rdStrobe = 1'b0;
    check("R11", "deselected write", enableReg, 8'h4F);
    check("R11", "deselected read", rdData, 8'h4F);
    repeat (2) @(negedge clk);
    check("R9", "rdData holds", rdData, 8'h4F);
  endtask

  task automatic testSameCycle();
    logic [7:0] d;
    doReset(5'd1);
    @(negedge clk);
    chipSel = 1'b1; addrLsb = DAT; rdStrobe = 1'b1; wrStrobe = 1'b1; wrData = 8'hC3;
    @(negedge clk);
    chipSel = 1'b0; rdStrobe = 1'b0; wrStrobe = 1'b0;
    check("R10", "data read sees old", rdData, 8'h4F);
    check("R10", "data write lands", enableReg, 8'hC3);
    @(negedge clk);
    chipSel = 1'b1; addrLsb = IDX; rdStrobe = 1'b1; wrStrobe = 1'b1; wrData = 8'h02;
    @(negedge clk);
    chipSel = 1'b0; rdStrobe = 1'b0; wrStrobe = 1'b0;
    check("R10", "index read sees id byte", rdData, 8'h88);
    busRead(IDX, d); check("R10", "index write lands", d, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testResetDefaults();
    testIdSequence();
    testRegAccess();
    testOutOfRange();
    testLock();
    testDeselect();
    testSameCycle();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule